// File: doc/BRIEF.md
# Double-Word Shift and Normalize Unit

This unit holds an 18-bit accumulator, an 18-bit extension register and a one-bit link. It shifts the accumulator alone, or the accumulator and extension register joined as one 36-bit word, by one place per clock. It also normalizes that 36-bit word. A 6-bit step counter sets the number of places. The counter counts upward and the operation ends when it reaches its end value. Software can read the counter back into the accumulator. Left, right and normalize operations each have a signed form, which first copies the accumulator sign into the link.

A controller loads the registers through write strobes while the unit is idle. It then issues an operation code and a count with a one-cycle start strobe, and waits for the one-cycle done pulse before it reads the results. The most significant bit of each register is bit 17 of its port. The accumulator MSB, `ac[17]`, is the sign.

Top module: `dws_unit`

## Requirements
- R1: After reset, ac, mq and link are 0, busy and done are low, and the step counter reads 0.
- R2: A long left shift (op 4) moves the joined word left one place per step. In each step mq[17] enters ac[0], the link enters mq[0] and ac[17] is discarded. The link itself is unchanged and never enters ac[0].
- R3: An accumulator left shift (op 3) moves ac left one place per step, with the link entering ac[0]. mq and the link are unchanged, and mq[17] never enters ac.
- R4: A shift operation (ops 3 to 7) with count 0 changes none of ac, mq and link. It holds busy for exactly one cycle and leaves the step counter at 0.
- R5: A long right shift (op 5) moves the joined word right one place per step. In each step the link enters ac[17], ac[0] enters mq[17] and mq[0] is discarded. The link is unchanged.
- R6: A shift of n places loads the counter with 64-n (mod 64) and adds 1 per step, so the counter ends at 0 after wrapping from 63. Op 2 writes the counter, zero-extended, into ac. Op 1 clears the counter, and op 0 changes nothing.
- R7: The signed forms are op 6 (left), op 7 (right) and op 9 (normalize). With a nonzero count each first copies ac[17] into the link, then behaves as its unsigned form (ops 4, 5 and 8).
- R8: Normalize (op 8) loads the counter with the bitwise inverse of the count. While ac[17] equals ac[16] and the counter is not 63, it performs a long-left step and adds 1 to the counter. With ac = octal 200000 and count 1 it does not shift and leaves the counter at octal 76. With ac = 0 and count 1 it shifts once and leaves the counter at octal 77.
- R9: For ops 3 to 9, busy is high from the cycle after start for (steps + 1) cycles. done is high for one cycle, in the first cycle with busy low. Ops 0 to 2 and unused codes raise done in the cycle after start and never raise busy.
- R10: A start strobe that arrives while busy is high is ignored.
- R11: While idle and without start, wr_ac, wr_mq and wr_link replace their registers with the given values. These writes are ignored while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle operation strobe |
| op | input | 4 | Operation code |
| count | input | 6 | Shift count or normalize limit |
| wr_ac | input | 1 | Write strobe for ac |
| wr_ac_val | input | 18 | Value for ac |
| wr_mq | input | 1 | Write strobe for mq |
| wr_mq_val | input | 18 | Value for mq |
| wr_link | input | 1 | Write strobe for link |
| wr_link_val | input | 1 | Value for link |
| ac | output | 18 | Accumulator |
| mq | output | 18 | Extension register |
| link | output | 1 | Link bit |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation finished (one-cycle pulse) |

## Verification
The bench tries single set bits and all-ones patterns with each link value. These show whether each boundary path (link to ac[0], mq[17] to ac[0], ac[0] to mq[17], link to ac[17]) is present and whether each forbidden path is absent. Counts of 0, 1, 18 and 36 separate an early or late stop from a correct one. Normalize is run on octal 200000, on zero and on random data, which tell an early sign-mismatch stop apart from a stop at the counter limit. The counter is read back after each operation. Random mixes of all shift kinds, with starts and writes injected while busy, expose wrong step counts and state that leaks between operations.

// File: rtl/dws_pkg.sv
package dws_pkg;

  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_SCCLR = 4'd1,
    OP_SCRD  = 4'd2,
    OP_ALS   = 4'd3,
    OP_LLS   = 4'd4,
    OP_LRS   = 4'd5,
    OP_LLSS  = 4'd6,
    OP_LRSS  = 4'd7,
    OP_NORM  = 4'd8,
    OP_NORMS = 4'd9
  } op_e;

  typedef enum logic [1:0] {
    DIR_ACL   = 2'd0,
    DIR_LONGL = 2'd1,
    DIR_LONGR = 2'd2
  } dir_e;

  typedef enum logic [2:0] {
    SC_HOLD = 3'd0,
    SC_CLR  = 3'd1,
    SC_NEG  = 3'd2,
    SC_INV  = 3'd3,
    SC_INC  = 3'd4
  } sc_cmd_e;

  typedef enum logic [2:0] {
    R_HOLD = 3'd0,
    R_SCRD = 3'd1,
    R_SIGN = 3'd2,
    R_STEP = 3'd3
  } reg_cmd_e;

endpackage

// File: rtl/dws_step_ctr.sv
module dws_step_ctr
  import dws_pkg::*;
#(
  parameter int SCW = 6
) (
  input  logic           clk,
  input  logic           rst_ni,
  input  sc_cmd_e        cmd,
  input  logic [SCW-1:0] cnt,
  output logic [SCW-1:0] sc,
  output logic           sc_zero,
  output logic           sc_full
);

  logic [SCW-1:0] sc_d;
  logic           sc_en;

  always_comb begin
    sc_d = sc;
    case (cmd)
      SC_CLR:  sc_d = '0;
      SC_NEG:  sc_d = SCW'(0) - cnt;
      SC_INV:  sc_d = ~cnt;
      SC_INC:  sc_d = sc + SCW'(1);
      default: sc_d = sc;
    endcase
  end

  assign sc_en = (cmd != SC_HOLD);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)    sc <= '0;
    else if (sc_en) sc <= sc_d;
  end

  assign sc_zero = (sc == '0);
  assign sc_full = (sc == '1);

  // R6: one step adds exactly one, wrapping at the top
  p_sc_step_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (cmd == SC_INC) |=> (sc == SCW'($past(sc) + SCW'(1))));

endmodule

// File: rtl/dws_shift_path.sv
module dws_shift_path
  import dws_pkg::*;
#(
  parameter int W = 18
) (
  input  logic [W-1:0] ac_i,
  input  logic [W-1:0] mq_i,
  input  logic         link_i,
  input  dir_e         dir,
  output logic [W-1:0] ac_o,
  output logic [W-1:0] mq_o
);

  always_comb begin
    ac_o = ac_i;
    mq_o = mq_i;
    case (dir)
      DIR_ACL: begin
        ac_o = {ac_i[W-2:0], link_i};
      end
      DIR_LONGL: begin
        ac_o = {ac_i[W-2:0], mq_i[W-1]};
        mq_o = {mq_i[W-2:0], link_i};
      end
      DIR_LONGR: begin
        ac_o = {link_i, ac_i[W-1:1]};
        mq_o = {ac_i[0], mq_i[W-1:1]};
      end
      default: begin
        ac_o = ac_i;
        mq_o = mq_i;
      end
    endcase
  end

endmodule

// File: rtl/dws_ctrl.sv
module dws_ctrl
  import dws_pkg::*;
#(
  parameter int SCW = 6
) (
  input  logic           clk,
  input  logic           rst_ni,
  input  logic           start,
  input  op_e            op,
  input  logic [SCW-1:0] cnt,
  input  logic           sc_zero,
  input  logic           sc_full,
  input  logic           nrm_diff,
  output sc_cmd_e        sc_cmd,
  output reg_cmd_e       reg_cmd,
  output dir_e           dir,
  output logic           busy,
  output logic           done
);

  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} st_e;

  st_e  st_q, st_d;
  op_e  mode_q, mode_d;
  logic mode_en;
  logic done_q, done_d;
  logic is_norm;
  logic stop;

  assign is_norm = (mode_q == OP_NORM) || (mode_q == OP_NORMS);
  assign stop    = is_norm ? (sc_full || nrm_diff) : sc_zero;

  always_comb begin
    st_d    = st_q;
    mode_d  = mode_q;
    mode_en = 1'b0;
    done_d  = 1'b0;
    sc_cmd  = SC_HOLD;
    reg_cmd = R_HOLD;
    if (st_q == ST_IDLE) begin
      if (start) begin
        case (op)
          OP_SCCLR: begin
            sc_cmd = SC_CLR;
            done_d = 1'b1;
          end
          OP_SCRD: begin
            reg_cmd = R_SCRD;
            done_d  = 1'b1;
          end
          OP_ALS, OP_LLS, OP_LRS, OP_LLSS, OP_LRSS: begin
            sc_cmd  = SC_NEG;
            st_d    = ST_RUN;
            mode_d  = op;
            mode_en = 1'b1;
            if ((op == OP_LLSS || op == OP_LRSS) && (cnt != '0))
              reg_cmd = R_SIGN;
          end
          OP_NORM, OP_NORMS: begin
            sc_cmd  = SC_INV;
            st_d    = ST_RUN;
            mode_d  = op;
            mode_en = 1'b1;
            if ((op == OP_NORMS) && (cnt != '0))
              reg_cmd = R_SIGN;
          end
          default: done_d = 1'b1;
        endcase
      end
    end else begin
      if (stop) begin
        st_d   = ST_IDLE;
        done_d = 1'b1;
      end else begin
        sc_cmd  = SC_INC;
        reg_cmd = R_STEP;
      end
    end
  end

  always_comb begin
    case (mode_q)
      OP_ALS:          dir = DIR_ACL;
      OP_LRS, OP_LRSS: dir = DIR_LONGR;
      default:         dir = DIR_LONGL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)      mode_q <= OP_NOP;
    else if (mode_en) mode_q <= mode_d;
  end

  assign busy = (st_q == ST_RUN);
  assign done = done_q;

  // R10: a start during a run does not change the latched operation
  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy && start) |=> (mode_q == $past(mode_q)));

  // R4: a shift run whose counter has reached zero finishes next cycle
  p_zero_stop_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy && !is_norm && sc_zero) |=> (done && !busy));

  // R8: normalize keeps running while sign bits agree and the limit is not reached
  p_norm_cont_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy && is_norm && !nrm_diff && !sc_full) |=> busy);

  // R9: done is only raised while idle
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    done |-> !busy);

endmodule

// File: rtl/dws_unit.sv
module dws_unit
  import dws_pkg::*;
#(
  parameter int W   = 18,
  parameter int SCW = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [3:0]     op,
  input  logic [SCW-1:0] count,
  input  logic           wr_ac,
  input  logic [W-1:0]   wr_ac_val,
  input  logic           wr_mq,
  input  logic [W-1:0]   wr_mq_val,
  input  logic           wr_link,
  input  logic           wr_link_val,
  output logic [W-1:0]   ac,
  output logic [W-1:0]   mq,
  output logic           link,
  output logic           busy,
  output logic           done
);

  localparam int PADW = W - SCW;

  logic [1:0]     rs_q;
  logic           rst_ni;
  sc_cmd_e        sc_cmd;
  reg_cmd_e       reg_cmd;
  dir_e           dir;
  logic [SCW-1:0] sc;
  logic           sc_zero;
  logic           sc_full;
  logic           nrm_diff;
  logic [W-1:0]   ac_q, ac_d, ac_s;
  logic [W-1:0]   mq_q, mq_d, mq_s;
  logic           link_q, link_d;
  logic           wr_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  assign nrm_diff = ac_q[W-1] ^ ac_q[W-2];

  dws_ctrl #(.SCW(SCW)) u_ctrl (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .start    (start),
    .op       (op_e'(op)),
    .cnt      (count),
    .sc_zero  (sc_zero),
    .sc_full  (sc_full),
    .nrm_diff (nrm_diff),
    .sc_cmd   (sc_cmd),
    .reg_cmd  (reg_cmd),
    .dir      (dir),
    .busy     (busy),
    .done     (done)
  );

  dws_step_ctr #(.SCW(SCW)) u_sc (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .cmd     (sc_cmd),
    .cnt     (count),
    .sc      (sc),
    .sc_zero (sc_zero),
    .sc_full (sc_full)
  );

  dws_shift_path #(.W(W)) u_path (
    .ac_i   (ac_q),
    .mq_i   (mq_q),
    .link_i (link_q),
    .dir    (dir),
    .ac_o   (ac_s),
    .mq_o   (mq_s)
  );

  assign wr_ok = !busy && !start;

  always_comb begin
    ac_d   = ac_q;
    mq_d   = mq_q;
    link_d = link_q;
    case (reg_cmd)
      R_SCRD: ac_d   = {{PADW{1'b0}}, sc};
      R_SIGN: link_d = ac_q[W-1];
      R_STEP: begin
        ac_d = ac_s;
        mq_d = mq_s;
      end
      default: begin
        if (wr_ok && wr_ac)   ac_d   = wr_ac_val;
        if (wr_ok && wr_mq)   mq_d   = wr_mq_val;
        if (wr_ok && wr_link) link_d = wr_link_val;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ac_q   <= '0;
      mq_q   <= '0;
      link_q <= 1'b0;
    end else begin
      ac_q   <= ac_d;
      mq_q   <= mq_d;
      link_q <= link_d;
    end
  end

  assign ac   = ac_q;
  assign mq   = mq_q;
  assign link = link_q;

  // R3: the accumulator-only shift never touches mq
  p_als_mq_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy && dir == DIR_ACL) |=> $stable(mq_q));

  // R2: the link stays fixed across the steps of a run
  p_link_hold_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy && $past(busy)) |-> $stable(link_q));

  // R11: writes during a run leave a long right shift on its bit path
  p_wr_busy_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy && dir == DIR_LONGR && !sc_zero) |=> (mq_q[W-1] == $past(ac_q[0])));

endmodule

// File: tb/sim_dws_unit.sv
module sim_dws_unit;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [3:0]  op;
  logic [5:0]  count;
  logic        wr_ac, wr_mq, wr_link;
  logic [17:0] wr_ac_val, wr_mq_val;
  logic        wr_link_val;
  logic [17:0] ac, mq;
  logic        link, busy, done;

  int n_chk;
  int n_bad;
  bit finished;

  logic [17:0] m_ac, m_mq;
  logic        m_link;
  logic [5:0]  m_sc;
  int          m_steps;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  dws_unit u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .count(count),
    .wr_ac(wr_ac), .wr_ac_val(wr_ac_val), .wr_mq(wr_mq), .wr_mq_val(wr_mq_val),
    .wr_link(wr_link), .wr_link_val(wr_link_val),
    .ac(ac), .mq(mq), .link(link), .busy(busy), .done(done)
  );

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic model(input int o, input int n);
    logic [5:0] c;
    c = 6'(n);
    m_steps = 0;
    case (o)
      1: m_sc = 6'd0;
      2: m_ac = {12'd0, m_sc};
      3, 4, 5, 6, 7: begin
        if ((o == 6 || o == 7) && n != 0) m_link = m_ac[17];
        m_sc = 6'd0 - c;
        while (m_sc != 6'd0) begin
          if (o == 3)                m_ac = {m_ac[16:0], m_link};
          else if (o == 4 || o == 6) {m_ac, m_mq} = {m_ac[16:0], m_mq[17], m_mq[16:0], m_link};
          else                       {m_ac, m_mq} = {m_link, m_ac, m_mq[17:1]};
          m_sc = m_sc + 6'd1;
          m_steps++;
        end
      end
      8, 9: begin
        if (o == 9 && n != 0) m_link = m_ac[17];
        m_sc = ~c;
        while (m_sc != 6'h3f && m_ac[17] == m_ac[16]) begin
          {m_ac, m_mq} = {m_ac[16:0], m_mq[17], m_mq[16:0], m_link};
          m_sc = m_sc + 6'd1;
          m_steps++;
        end
      end
      default: ;
    endcase
  endtask

  task automatic load(input logic [17:0] a, input logic [17:0] q, input logic l);
    @(negedge clk);
    wr_ac = 1'b1; wr_ac_val = a;
    wr_mq = 1'b1; wr_mq_val = q;
    wr_link = 1'b1; wr_link_val = l;
    @(negedge clk);
    wr_ac = 1'b0; wr_mq = 1'b0; wr_link = 1'b0;
    m_ac = a; m_mq = q; m_link = l;
  endtask

  // poke: 0 none, 1 start during busy, 2 register writes during busy
  task automatic apply(input string tag, input int o, input int n, input int poke);
    int bc;
    int guard;
    int exp_bc;
    @(negedge clk);
    start = 1'b1; op = 4'(o); count = 6'(n);
    @(negedge clk);
    start = 1'b0;
    bc = 0;
    guard = 0;
    while (!done && guard < 200) begin
      if (busy) begin
        bc++;
        if (bc == 1 && poke == 1) begin
          start = 1'b1; op = 4'd1; count = 6'd5;
        end
        if (bc == 1 && poke == 2) begin
          wr_ac = 1'b1; wr_ac_val = ~ac;
          wr_mq = 1'b1; wr_mq_val = ~mq;
          wr_link = 1'b1; wr_link_val = ~link;
        end
      end
      @(negedge clk);
      start = 1'b0; wr_ac = 1'b0; wr_mq = 1'b0; wr_link = 1'b0;
      guard++;
    end
    model(o, n);
    exp_bc = (o >= 3 && o <= 9) ? m_steps + 1 : 0;
    check({tag, " done seen"}, 64'(done), 64'd1);
    check({tag, " busy cycles"}, 64'(bc), 64'(exp_bc));
    check({tag, " ac"}, 64'(ac), 64'(m_ac));
    check({tag, " mq"}, 64'(mq), 64'(m_mq));
    check({tag, " link"}, 64'(link), 64'(m_link));
  endtask

  task automatic read_sc(input string tag);
    apply({tag, " sc readback"}, 2, 0, 0);
  endtask

  initial begin
    finished = 1'b0;
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_bad = 0;
    void'($urandom(32'd4242));
    rst_n = 1'b0; start = 1'b0; op = 4'd0; count = 6'd0;
    wr_ac = 1'b0; wr_mq = 1'b0; wr_link = 1'b0;
    wr_ac_val = '0; wr_mq_val = '0; wr_link_val = 1'b0;
    m_ac = '0; m_mq = '0; m_link = 1'b0; m_sc = '0; m_steps = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 ac", 64'(ac), 64'd0);
    check("R1 mq", 64'(mq), 64'd0);
    check("R1 link", 64'(link), 64'd0);
    check("R1 busy", 64'(busy), 64'd0);
    check("R1 done", 64'(done), 64'd0);
    read_sc("R1");

    // R11 idle writes
    load(18'o123456, 18'o654321, 1'b1);
    check("R11 ac write", 64'(ac), 64'(18'o123456));
    check("R11 mq write", 64'(mq), 64'(18'o654321));
    check("R11 link write", 64'(link), 64'd1);

    // R2 long left paths: mq msb to ac lsb, link to mq lsb, not to ac
    load(18'o0, 18'o400000, 1'b1);
    apply("R2 lls 1", 4, 1, 0);
    load(18'o0, 18'o0, 1'b1);
    apply("R2 lls 18", 4, 18, 0);
    load(18'o777777, 18'o777777, 1'b0);
    apply("R2 lls 36", 4, 36, 0);

    // R3 accumulator-only left
    load(18'o0, 18'o777777, 1'b1);
    apply("R3 als 1", 3, 1, 0);
    load(18'o000001, 18'o400000, 1'b0);
    apply("R3 als 17", 3, 17, 0);

    // R4 zero count
    load(18'o525252, 18'o252525, 1'b1);
    apply("R4 lls 0", 4, 0, 0);
    apply("R4 lrss 0", 7, 0, 0);
    read_sc("R4");

    // R5 long right
    load(18'o000001, 18'o0, 1'b1);
    apply("R5 lrs 1", 5, 1, 0);
    load(18'o400000, 18'o000001, 1'b0);
    apply("R5 lrs 36", 5, 36, 0);

    // R6 counter behaviour
    load(18'o200000, 18'o0, 1'b0);
    apply("R6 norm set", 8, 1, 0);
    apply("R6 nop", 0, 0, 0);
    read_sc("R6 after nop");
    apply("R6 clear", 1, 0, 0);
    read_sc("R6 after clear");
    load(18'o1, 18'o2, 1'b0);
    apply("R6 lrs 5", 5, 5, 0);
    read_sc("R6 wrap to zero");

    // R7 signed forms and round trip
    load(18'o700123, 18'o123456, 1'b0);
    apply("R7 llss 2", 6, 2, 0);
    apply("R7 lrs back 2", 5, 2, 0);
    check("R7 round trip ac", 64'(ac), 64'(18'o700123));
    check("R7 round trip mq", 64'(mq), 64'(18'o123456));
    load(18'o400000, 18'o0, 1'b0);
    apply("R7 lrss 3", 7, 3, 0);
    load(18'o770000, 18'o0, 1'b0);
    apply("R7 norms 10", 9, 10, 0);

    // R8 normalize corners
    load(18'o200000, 18'o0, 1'b0);
    apply("R8 norm no shift", 8, 1, 0);
    read_sc("R8 octal 76");
    load(18'o0, 18'o0, 1'b0);
    apply("R8 norm one shift", 8, 1, 0);
    read_sc("R8 octal 77");
    load(18'o0, 18'o000100, 1'b0);
    apply("R8 norm limit", 8, 63, 0);

    // R9 immediate op on an unused code
    apply("R9 unused code", 12, 0, 0);

    // R10 start while busy
    load(18'o111111, 18'o222222, 1'b1);
    apply("R10 start ignored", 4, 7, 1);
    read_sc("R10");

    // R11 writes while busy
    apply("R11 write ignored", 5, 9, 2);

    // random mix
    for (int i = 0; i < 300; i++) begin
      int o;
      int n;
      int pk;
      o = int'($urandom_range(3, 9));
      n = (o >= 8) ? int'($urandom_range(0, 63)) : int'($urandom_range(0, 36));
      pk = int'($urandom_range(0, 5));
      if (pk > 2) pk = 0;
      load(18'($urandom), 18'($urandom), 1'($urandom));
      apply("R9 random op", o, n, pk);
      read_sc("R6 random");
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule